// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block generates the address stream for one DMA work unit. When it is idle, a start pulse loads a program. The program holds a base address, an unsigned 16-bit element count per row, a signed 16-bit element stride, an unsigned 16-bit row count and a signed 16-bit row stride. The block then walks an inner loop across the elements of a row, nested inside an outer loop over the rows. It presents one address per beat on a valid/ready handshake.

Within a row, the address moves by the element stride after each accepted beat. After the last element of a row, it moves by the row stride instead and the element counter reloads. Both strides are signed, so the walk can run backward. This lets a transfer cover a rectangle, a column or a strided block, not only a linear burst.

The remaining element and row counts appear on output ports while the unit runs. A single-cycle done pulse follows the final accepted beat. A flat mode uses only the element count and element stride. A count of zero is treated as one.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, valid_o, busy_o and done_o are 0, and addr_o, cur_x_o and cur_y_o read 0.
- R2: A start_i pulse while idle latches the program. From the next cycle, valid_o and busy_o are 1, addr_o equals start_addr_i, cur_x_o equals the effective element count and cur_y_o equals the effective row count. Program inputs may change after the start cycle without effect.
- R3: An accepted beat (valid_o and ready_i both 1) with cur_x_o greater than 1 adds the sign-extended element stride to addr_o and lowers cur_x_o by one.
- R4: An accepted beat with cur_x_o equal to 1 and cur_y_o greater than 1 adds the sign-extended row stride to addr_o, reloads cur_x_o with the effective element count and lowers cur_y_o by one.
- R5: Both strides are two's-complement values. Address arithmetic wraps modulo 2^ADDR_W.
- R6: Exactly (effective element count × effective row count) beats are offered. In the cycle after the final accepted beat, done_o is 1 for one cycle only, and valid_o and busy_o are 0. cur_x_o and cur_y_o then read 0.
- R7: An element count or row count of 0 behaves as a count of 1. An all-zero program therefore offers a single beat.
- R8: When flat_i is 1 at start, y_cnt_i and y_mod_i have no effect. cur_y_o reads 1 for the whole run.
- R9: While valid_o is 1 and ready_i is 0, addr_o, cur_x_o and cur_y_o hold their values and valid_o stays 1.
- R10: A start_i pulse while busy_o is 1 is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the program and begin; honoured only when idle |
| flat_i | input | 1 | 1 selects one-dimensional mode |
| start_addr_i | input | ADDR_W | Base address |
| x_cnt_i | input | CNT_W | Elements per row, unsigned |
| x_mod_i | input | MOD_W | Element stride, signed |
| y_cnt_i | input | CNT_W | Row count, unsigned |
| y_mod_i | input | MOD_W | Row stride (last element to next row start), signed |
| valid_o | output | 1 | Address valid |
| ready_i | input | 1 | Consumer accepts the address |
| addr_o | output | ADDR_W | Current address |
| cur_x_o | output | CNT_W | Elements left in the current row, including the current one |
| cur_y_o | output | CNT_W | Rows left, including the current one |
| busy_o | output | 1 | Unit in progress |
| done_o | output | 1 | One-cycle pulse after the final beat |

## Verification
The bound checker watches four cycle-level rules on every cycle:
- the handshake hold under back-pressure;
- the single-cycle done pulse that directly follows an accepted beat;
- the element counter never reading zero, and stepping down by one, while addresses are offered;
- cleared counters whenever the unit is idle.

Only the bench scenarios can show the actual address sequence. That covers stride sign extension, the row-stride substitution at row ends, the total beat count, zero-count promotion, the ignored row fields in flat mode, and the rejected restart while busy. Each of these depends on the program as a whole, not on a single cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gen_state_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_X    = 2'd2,
    STEP_Y    = 2'd3
  } step_e;
endpackage

// File: rtl/dma2d_loop_cnt.sv
module dma2d_loop_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff_val;

  // zero count is promoted to a single element
  assign eff_val = (load_val_i == '0) ? ONE : load_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= eff_val;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/dma2d_addr_step.sv
module dma2d_addr_step
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MOD_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_e             step_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [MOD_W-1:0]  mod_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - MOD_W;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] mod_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign mod_ext = {{EXT_W{mod_i[MOD_W-1]}}, mod_i};
    end else begin : g_trunc
      assign mod_ext = mod_i[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else begin
      unique case (step_i)
        STEP_LOAD:      addr_q <= load_addr_i;
        STEP_X, STEP_Y: addr_q <= addr_q + mod_ext;
        default:        addr_q <= addr_q;
      endcase
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma2d_seq_ctrl.sv
module dma2d_seq_ctrl
  import dma2d_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int MOD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             flat_i,
  input  logic [CNT_W-1:0] x_cnt_i,
  input  logic [MOD_W-1:0] x_mod_i,
  input  logic [CNT_W-1:0] y_cnt_i,
  input  logic [MOD_W-1:0] y_mod_i,
  input  logic             ready_i,
  input  logic             x_last_i,
  input  logic             y_last_i,
  output logic             valid_o,
  output logic             busy_o,
  output logic             done_o,
  output step_e            step_o,
  output logic [MOD_W-1:0] step_mod_o,
  output logic             cnt_clr_o,
  output logic             x_load_o,
  output logic [CNT_W-1:0] x_load_val_o,
  output logic             x_dec_o,
  output logic             y_load_o,
  output logic [CNT_W-1:0] y_load_val_o,
  output logic             y_dec_o
);
  gen_state_e       state_q, state_d;
  logic [CNT_W-1:0] x_len_q;
  logic [MOD_W-1:0] x_mod_q, y_mod_q;
  logic             done_q;

  logic start_ok, beat, row_end, final_beat;

  assign start_ok   = start_i && (state_q == ST_IDLE);
  assign beat       = (state_q == ST_RUN) && ready_i;
  assign row_end    = beat && x_last_i && !y_last_i;
  assign final_beat = beat && x_last_i && y_last_i;

  always_comb begin
    state_d = state_q;
    if (start_ok)   state_d = ST_RUN;
    if (final_beat) state_d = ST_IDLE;
  end

  always_comb begin
    step_o = STEP_HOLD;
    if (start_ok)                 step_o = STEP_LOAD;
    else if (beat && !x_last_i)   step_o = STEP_X;
    else if (row_end)             step_o = STEP_Y;
  end

  assign step_mod_o   = (step_o == STEP_Y) ? y_mod_q : x_mod_q;
  assign cnt_clr_o    = final_beat;
  assign x_load_o     = start_ok || row_end;
  assign x_load_val_o = start_ok ? x_cnt_i : x_len_q;
  assign x_dec_o      = beat && !x_last_i;
  assign y_load_o     = start_ok;
  assign y_load_val_o = flat_i ? CNT_W'(1) : y_cnt_i;
  assign y_dec_o      = row_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      x_len_q <= '0;
      x_mod_q <= '0;
      y_mod_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= final_beat;
      if (start_ok) begin
        x_len_q <= x_cnt_i;
        x_mod_q <= x_mod_i;
        y_mod_q <= y_mod_i;
      end
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = done_q;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              flat_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  x_cnt_i,
  input  logic [MOD_W-1:0]  x_mod_i,
  input  logic [CNT_W-1:0]  y_cnt_i,
  input  logic [MOD_W-1:0]  y_mod_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cur_x_o,
  output logic [CNT_W-1:0]  cur_y_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int N_LOOPS = 2;

  step_e            step;
  logic [MOD_W-1:0] step_mod;
  logic             cnt_clr;
  logic             ld   [N_LOOPS];
  logic [CNT_W-1:0] ldv  [N_LOOPS];
  logic             dec  [N_LOOPS];
  logic [CNT_W-1:0] cnt  [N_LOOPS];
  logic             last [N_LOOPS];

  dma2d_seq_ctrl #(.CNT_W(CNT_W), .MOD_W(MOD_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .flat_i       (flat_i),
    .x_cnt_i      (x_cnt_i),
    .x_mod_i      (x_mod_i),
    .y_cnt_i      (y_cnt_i),
    .y_mod_i      (y_mod_i),
    .ready_i      (ready_i),
    .x_last_i     (last[0]),
    .y_last_i     (last[1]),
    .valid_o      (valid_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .step_o       (step),
    .step_mod_o   (step_mod),
    .cnt_clr_o    (cnt_clr),
    .x_load_o     (ld[0]),
    .x_load_val_o (ldv[0]),
    .x_dec_o      (dec[0]),
    .y_load_o     (ld[1]),
    .y_load_val_o (ldv[1]),
    .y_dec_o      (dec[1])
  );

  // index 0: element loop, index 1: row loop
  generate
    for (genvar i = 0; i < N_LOOPS; i++) begin : g_loop
      dma2d_loop_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (cnt_clr),
        .load_i     (ld[i]),
        .load_val_i (ldv[i]),
        .dec_i      (dec[i]),
        .cnt_o      (cnt[i]),
        .last_o     (last[i])
      );
    end
  endgenerate

  dma2d_addr_step #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .load_addr_i (start_addr_i),
    .mod_i       (step_mod),
    .addr_o      (addr_o)
  );

  assign cur_x_o = cnt[0];
  assign cur_y_o = cnt[1];
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_o,
  input logic              ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  cur_x_o,
  input logic [CNT_W-1:0]  cur_y_o,
  input logic              busy_o,
  input logic              done_o
);
  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(cur_x_o) && $stable(cur_y_o));

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_beat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_o && ready_i) && !valid_o);

  p_idle_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !valid_o && cur_x_o == '0 && cur_y_o == '0);

  p_counts_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cur_x_o != '0 && cur_y_o != '0);

  p_x_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && cur_x_o > CNT_W'(1) |=> cur_x_o == $past(cur_x_o) - CNT_W'(1));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .ready_i (ready_i),
  .addr_o  (addr_o),
  .cur_x_o (cur_x_o),
  .cur_y_o (cur_y_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, flat = 1'b0, ready = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic [CW-1:0] xc = '0, xm = '0, yc = '0, ym = '0;
  logic          valid, busy, done;
  logic [AW-1:0] addr;
  logic [CW-1:0] cx, cy;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma2d_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .flat_i(flat),
    .start_addr_i(saddr), .x_cnt_i(xc), .x_mod_i(xm), .y_cnt_i(yc), .y_mod_i(ym),
    .valid_o(valid), .ready_i(ready), .addr_o(addr), .cur_x_o(cx), .cur_y_o(cy),
    .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // runs one program; beats checked against a model built from R2..R10
  task automatic run_prog(input string req, input logic [AW-1:0] sa,
                          input logic [CW-1:0] pxc, input logic [CW-1:0] pxm,
                          input logic [CW-1:0] pyc, input logic [CW-1:0] pym,
                          input bit pflat, input int stall_mod, input bit poke);
    int ex, ey, beat;
    logic [AW-1:0] a;
    ex = (pxc == 0) ? 1 : int'(pxc);
    ey = pflat ? 1 : ((pyc == 0) ? 1 : int'(pyc));
    @(negedge clk);
    saddr = sa; xc = pxc; xm = pxm; yc = pyc; ym = pym; flat = pflat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble program inputs: latched values must govern (R2)
    saddr = 32'hDEAD_BEE0; xc = 16'd9; xm = 16'h5555; yc = 16'd9; ym = 16'h7777; flat = ~pflat;
    a = sa; beat = 0;
    for (int r = 0; r < ey; r++) begin
      for (int c = 0; c < ex; c++) begin
        check(valid === 1'b1, (beat == 0) ? "R2" : req, "valid", 64'(valid), 64'd1);
        check(addr === a, (beat == 0) ? "R2" : req, "addr", 64'(addr), 64'(a));
        check(cx === CW'(ex - c), (c == 0) ? "R4" : "R3", "cur_x", 64'(cx), 64'(ex - c));
        check(cy === CW'(ey - r), pflat ? "R8" : "R4", "cur_y", 64'(cy), 64'(ey - r));
        if (stall_mod != 0 && (beat % stall_mod) == 0) begin
          ready = 1'b0;
          @(negedge clk);
          check(valid === 1'b1 && addr === a && cx === CW'(ex - c) && cy === CW'(ey - r),
                "R9", "stall hold addr", 64'(addr), 64'(a));
        end
        ready = 1'b1;
        start = poke && (beat == 1);
        @(negedge clk);
        start = 1'b0;
        if (c < ex - 1) a = a + {{(AW-CW){pxm[CW-1]}}, pxm};
        else            a = a + {{(AW-CW){pym[CW-1]}}, pym};
        beat++;
      end
    end
    ready = 1'b0;
    check(done === 1'b1, "R6", "done pulse", 64'(done), 64'd1);
    check(valid === 1'b0 && busy === 1'b0, "R6", "valid/busy after last", 64'({valid, busy}), 64'd0);
    check(cx === '0 && cy === '0, "R6", "counts cleared", 64'({cx, cy}), 64'd0);
    @(negedge clk);
    check(done === 1'b0, "R6", "done width", 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    check(valid === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "flags", 64'({valid, busy, done}), 64'd0);
    check(addr === '0 && cx === '0 && cy === '0, "R1", "addr/counts", 64'(addr), 64'd0);
  endtask

  task automatic t_flat();
    // row fields are nonzero but must be ignored (R8)
    run_prog("R8", 32'h0000_1000, 16'd5, 16'd4, 16'd7, 16'h0100, 1'b1, 0, 1'b0);
  endtask

  task automatic t_rows();
    run_prog("R4", 32'h0000_2000, 16'd3, 16'd2, 16'd4, 16'd10, 1'b0, 0, 1'b0);
  endtask

  task automatic t_backward();
    // negative strides, base near zero so the walk wraps (R5)
    run_prog("R5", 32'h0000_0008, 16'd4, 16'hFFFC, 16'd3, 16'hFFE0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_zero();
    run_prog("R7", 32'h0000_0300, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 0, 1'b0);
    run_prog("R7", 32'h0000_0400, 16'd0, 16'd8, 16'd3, 16'd16, 1'b0, 0, 1'b0);
  endtask

  task automatic t_stall();
    run_prog("R9", 32'h0000_5000, 16'd3, 16'd1, 16'd2, 16'd64, 1'b0, 2, 1'b0);
  endtask

  task automatic t_restart_ignored();
    run_prog("R10", 32'h0000_6000, 16'd3, 16'd8, 16'd2, 16'd100, 1'b0, 0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_rows();
    t_backward();
    t_zero();
    t_stall();
    t_restart_ignored();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule